// File: doc/BRIEF.md
# Seconds Timer with Alarm

This block is a memory-mapped real-time timer. A slow clock reaches it as a one-cycle enable pulse in the bus clock domain. A programmable prescaler divides those pulses, and each time the prescaler wraps, a 32-bit up-counter advances by one. When the divisor equals the slow-clock rate (32768 for a 32.768 kHz source), the counter counts seconds.

Software cannot load the counter. It can only restart the counter, together with the prescaler, from zero through a self-clearing bit in the mode register. A 32-bit alarm register is compared against the counter. Two sticky status flags record an alarm match and a counter increment, and both clear when the status register is read. Each flag has its own enable bit, and the single interrupt line is the OR of the enabled flags. A separate 32-bit retained register holds the base offset that software adds to the count to form wall-clock time; a value of zero means the time has never been set.

Bus reads return data combinationally in the cycle the access is presented. Writes and the clear-on-read take effect at the clock edge that ends the access.

Top module: `sec_timer`

## Requirements
- R1: The word address on `bus_addr` selects the register: 0 = mode, 1 = alarm, 2 = counter value, 3 = status, 4 = retained offset. Mode bits [15:0] are the divisor, bit 16 is the alarm interrupt enable, bit 17 is the increment interrupt enable and bit 18 is the restart command. In the status register, bit 0 is the alarm flag and bit 1 is the increment flag.
- R2: After reset, the registers read as follows: mode 0x00008000, alarm 0xFFFFFFFF, counter 0, status 0 and retained 0. `irq` is low.
- R3: With a divisor D in 1..65535, the counter advances by one on every D-th clock edge at which `slow_tick` is high. A divisor of 0 divides by 65536.
- R4: Writing the mode register with bit 18 set zeroes both the counter and the prescaler at that edge. Bit 18 always reads back as 0.
- R5: Writes to the counter value and status addresses are ignored.
- R6: The alarm flag sets at the edge where the counter advances to a value equal to the alarm register. It does not set again while the counter moves past that value.
- R7: The increment flag sets at every counter advance, whether or not its interrupt enable is set.
- R8: A read of the status register returns the flags and clears them. An event that arrives in the same cycle as the read is not returned by that read and stays set for the next read.
- R9: `irq` is high exactly when (alarm flag AND mode bit 16) OR (increment flag AND mode bit 17).
- R10: The retained register reads back the last value written and is touched by nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase shows up as a counter read that is one count early or late after the next whole divisor period of ticks. A missed restart leaves a non-zero count in the first read after the mode write. A stale or lost status flag shows up at once in two places: the level on `irq` and the value returned by the next status read. A clear-on-read race that drops a same-cycle event can only be seen on the read that follows, so the bench deliberately places an increment inside a status read and then reads the status again.

// File: rtl/ssec_pkg.sv
// Shared constants for the seconds timer: register word addresses and
// the bit positions of the mode and status fields.
// Assumes a word-addressed register bus of ADDR_W bits.
package ssec_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 3'd0,
        A_ALARM  = 3'd1,
        A_COUNT  = 3'd2,
        A_STATUS = 3'd3,
        A_RETAIN = 3'd4
    } reg_addr_t;

    localparam int B_ALM_EN  = 16;
    localparam int B_INC_EN  = 17;
    localparam int B_RESTART = 18;
    localparam int B_ALM_ST  = 0;
    localparam int B_INC_ST  = 1;
endpackage

// File: rtl/ssec_prescaler.sv
// Divides slow_tick pulses by a programmable divisor.
// wrap is high for the tick that completes a period. A divisor of 0
// divides by 2**PRESC_W, because divisor-1 wraps to all ones.
// Assumes slow_tick is already synchronous to clk.
module ssec_prescaler #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               slow_tick,
    input  logic [PRESC_W-1:0] divisor,
    output logic               wrap
);
    logic [PRESC_W-1:0] phase;
    logic [PRESC_W-1:0] last;

    // terminal phase of one period
    assign last = divisor - PRESC_W'(1);
    // >= so that lowering the divisor mid-period cannot strand the phase
    assign wrap = slow_tick && !restart && (phase >= last);

    // phase counter: restart zeroes it, a wrap returns it to zero
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= '0;
        end else if (slow_tick) begin
            phase <= wrap ? '0 : phase + PRESC_W'(1);
        end
    end
endmodule

// File: rtl/ssec_counter.sv
// Up-counter with an alarm comparator. hit pulses when the coming
// increment makes the counter equal to the alarm value, so the alarm
// flag sets on the same edge the counter reaches it.
module ssec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             inc,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [CNT_W-1:0] next_val;

    // value the counter takes on an increment
    assign next_val = count + CNT_W'(1);
    // match detection on the advance only
    assign hit = inc && (next_val == alarm);

    // counter register: restart has priority over an increment
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (inc) begin
            count <= next_val;
        end
    end
endmodule

// File: rtl/ssec_status.sv
// Sticky event flags with clear-on-read. An event that arrives in the
// same cycle as the clearing read wins, so it is never lost.
module ssec_status #(
    parameter int N_EV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] events,
    input  logic            rd_clr,
    output logic [N_EV-1:0] flags
);
    // one sticky bit per event source
    for (genvar i = 0; i < N_EV; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (events[i]) begin
                flags[i] <= 1'b1;
            end else if (rd_clr) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sec_timer.sv
// Seconds timer top: register file, read mux and interrupt.
// Assumes single-cycle bus accesses and a slow_tick already in the clk domain.
module sec_timer
    import ssec_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          PRESC_W   = 16,
    parameter logic [15:0] PRESC_RST = 16'd32768
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    slow_tick,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [ssec_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    irq
);
    localparam int N_EV = 2;

    logic [PRESC_W-1:0] divisor;
    logic               alm_en;
    logic               inc_en;
    logic [DATA_W-1:0]  alarm;
    logic [DATA_W-1:0]  retain;
    logic [DATA_W-1:0]  count;
    logic [N_EV-1:0]    flags;
    logic               wr, rd;
    logic               restart;
    logic               wrap;
    logic               hit;
    logic               rd_clr;
    logic               retain_we;

    // access decode
    assign wr        = bus_sel && bus_we;
    assign rd        = bus_sel && !bus_we;
    assign restart   = wr && (bus_addr == A_MODE) && bus_wdata[B_RESTART];
    assign rd_clr    = rd && (bus_addr == A_STATUS);
    assign retain_we = wr && (bus_addr == A_RETAIN);

    // mode and alarm registers; the restart bit is not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor <= PRESC_W'(PRESC_RST);
            alm_en  <= 1'b0;
            inc_en  <= 1'b0;
            alarm   <= '1;
        end else if (wr) begin
            if (bus_addr == A_MODE) begin
                divisor <= bus_wdata[PRESC_W-1:0];
                alm_en  <= bus_wdata[B_ALM_EN];
                inc_en  <= bus_wdata[B_INC_EN];
            end
            if (bus_addr == A_ALARM) begin
                alarm <= bus_wdata;
            end
        end
    end

    // retained offset register, software only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retain <= '0;
        end else if (retain_we) begin
            retain <= bus_wdata;
        end
    end

    ssec_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .slow_tick(slow_tick), .divisor(divisor), .wrap(wrap)
    );

    ssec_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .inc(wrap), .alarm(alarm), .count(count), .hit(hit)
    );

    ssec_status #(.N_EV(N_EV)) u_stat (
        .clk(clk), .rst_n(rst_n), .events({wrap, hit}),
        .rd_clr(rd_clr), .flags(flags)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE: begin
                bus_rdata[PRESC_W-1:0] = divisor;
                bus_rdata[B_ALM_EN]    = alm_en;
                bus_rdata[B_INC_EN]    = inc_en;
            end
            A_ALARM:  bus_rdata = alarm;
            A_COUNT:  bus_rdata = count;
            A_STATUS: bus_rdata[N_EV-1:0] = flags;
            A_RETAIN: bus_rdata = retain;
            default:  bus_rdata = '0;
        endcase
    end

    // interrupt: each flag gated by the enable 16 bits above it
    assign irq = (flags[B_ALM_ST] && alm_en) || (flags[B_INC_ST] && inc_en);
endmodule

// File: rtl/sec_timer_chk.sv
// Assertion checker for sec_timer, attached by bind below.
module sec_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] alarm,
    input logic [1:0]        flags,
    input logic              rd_clr,
    input logic              wrap,
    input logic              hit,
    input logic              irq,
    input logic              retain_we,
    input logic [DATA_W-1:0] retain
);
    // R4: a restart leaves the counter at zero
    p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));

    // R3: the counter only steps by one or returns to zero
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (count == $past(count) + DATA_W'(1)) || (count == '0));

    // R6: the alarm flag rises only when the counter equals the alarm
    p_alarm_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> (count == alarm));

    // R8: a status read with no new event clears the flags
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !wrap && !hit) |=> (flags == 2'b00));

    // R9: interrupt drops after a clean status read
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !wrap && !hit) |=> !irq);

    // R10: the retained register changes only when written
    p_retain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !retain_we |=> $stable(retain));
endmodule

bind sec_timer sec_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .count(count),
    .alarm(alarm), .flags(flags), .rd_clr(rd_clr), .wrap(wrap),
    .hit(hit), .irq(irq), .retain_we(retain_we), .retain(retain)
);

// File: tb/sim_sec_timer.sv
// Self-checking bench for sec_timer: a vector table walked by one loop,
// then directed tests for the same-cycle read, divisor 0 and reset.
module sim_sec_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    sec_timer u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // vector: {op[1:0], req[3:0], addr[2:0], data[31:0], exp[31:0]}
    localparam logic [1:0] WR = 2'd0, RD = 2'd1, TK = 2'd2, IQ = 2'd3;
    localparam logic [2:0] M = 3'd0, A = 3'd1, C = 3'd2, S = 3'd3, G = 3'd4;
    localparam int NV = 46;
    localparam logic [72:0] VEC [NV] = '{
        {RD, 4'd2,  M, 32'h0, 32'h0000_8000},   // R2
        {RD, 4'd2,  A, 32'h0, 32'hFFFF_FFFF},   // R2
        {RD, 4'd2,  C, 32'h0, 32'h0},           // R2
        {RD, 4'd2,  S, 32'h0, 32'h0},           // R2
        {RD, 4'd2,  G, 32'h0, 32'h0},           // R2
        {IQ, 4'd2,  M, 32'h0, 32'h0},           // R2
        {WR, 4'd4,  M, 32'h0004_0003, 32'h0},   // R4 restart, divisor 3
        {RD, 4'd4,  M, 32'h0, 32'h0000_0003},   // R4 bit 18 reads 0
        {WR, 4'd10, G, 32'h1234_5678, 32'h0},   // R10
        {RD, 4'd10, G, 32'h0, 32'h1234_5678},   // R10
        {TK, 4'd3,  M, 32'd2, 32'h0},           // R3
        {RD, 4'd3,  C, 32'h0, 32'h0},           // R3 two ticks: no step
        {TK, 4'd3,  M, 32'd1, 32'h0},           // R3
        {RD, 4'd3,  C, 32'h0, 32'h1},           // R3 third tick steps
        {IQ, 4'd9,  M, 32'h0, 32'h0},           // R9 flag set, enable off
        {RD, 4'd7,  S, 32'h0, 32'h2},           // R7
        {RD, 4'd8,  S, 32'h0, 32'h0},           // R8 cleared
        {WR, 4'd5,  C, 32'h55, 32'h0},          // R5
        {WR, 4'd5,  S, 32'h3, 32'h0},           // R5
        {RD, 4'd5,  C, 32'h0, 32'h1},           // R5
        {RD, 4'd5,  S, 32'h0, 32'h0},           // R5
        {WR, 4'd6,  A, 32'h3, 32'h0},           // R6
        {TK, 4'd6,  M, 32'd6, 32'h0},           // R6
        {RD, 4'd6,  C, 32'h0, 32'h3},           // R6
        {RD, 4'd6,  S, 32'h0, 32'h3},           // R6 alarm + increment
        {TK, 4'd6,  M, 32'd3, 32'h0},           // R6
        {RD, 4'd6,  C, 32'h0, 32'h4},           // R6
        {RD, 4'd6,  S, 32'h0, 32'h2},           // R6 no repeat alarm
        {TK, 4'd4,  M, 32'd2, 32'h0},           // R4 prescaler mid-period
        {WR, 4'd4,  M, 32'h0004_0003, 32'h0},   // R4
        {TK, 4'd4,  M, 32'd2, 32'h0},           // R4
        {RD, 4'd4,  C, 32'h0, 32'h0},           // R4 prescaler was zeroed
        {TK, 4'd4,  M, 32'd1, 32'h0},           // R4
        {RD, 4'd4,  C, 32'h0, 32'h1},           // R4
        {RD, 4'd8,  S, 32'h0, 32'h2},           // R8
        {WR, 4'd9,  M, 32'h0001_0003, 32'h0},   // R9 alarm enable
        {TK, 4'd9,  M, 32'd6, 32'h0},           // R9
        {IQ, 4'd9,  M, 32'h0, 32'h1},           // R9
        {RD, 4'd9,  S, 32'h0, 32'h3},           // R9
        {IQ, 4'd9,  M, 32'h0, 32'h0},           // R9
        {WR, 4'd9,  M, 32'h0002_0003, 32'h0},   // R9 increment enable
        {TK, 4'd9,  M, 32'd3, 32'h0},           // R9
        {IQ, 4'd9,  M, 32'h0, 32'h1},           // R9
        {RD, 4'd7,  S, 32'h0, 32'h2},           // R7
        {IQ, 4'd9,  M, 32'h0, 32'h0},           // R9
        {RD, 4'd1,  M, 32'h0, 32'h0002_0003}    // R1 field layout
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slow_tick = 1'b1;
            @(negedge clk) slow_tick = 1'b0;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [2:0]  ad;
            logic [31:0] dt, ex;
            {op, rq, ad, dt, ex} = VEC[i];
            case (op)
                WR: bus_wr(ad, dt);
                RD: begin bus_rd(ad, v); check(int'(rq), v, ex); end
                TK: ticks(int'(dt));
                default: begin
                    @(negedge clk);
                    check(int'(rq), {31'd0, irq}, ex);
                end
            endcase
        end

        // R8: increment lands in the same cycle as the status read
        bus_wr(M, 32'h0004_0001);
        bus_rd(S, v);
        @(negedge clk);
        slow_tick = 1'b1; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = S;
        #1 v = bus_rdata;
        @(negedge clk);
        slow_tick = 1'b0; bus_sel = 1'b0;
        check(8, v, 32'h0);
        bus_rd(S, v);
        check(8, v, 32'h2);
        bus_rd(C, v);
        check(3, v, 32'h1);

        // R3: divisor 0 divides by 65536
        bus_wr(M, 32'h0004_0000);
        @(negedge clk) slow_tick = 1'b1;
        repeat (65535) @(negedge clk);
        slow_tick = 1'b0;
        bus_rd(C, v);
        check(3, v, 32'h0);
        ticks(1);
        bus_rd(C, v);
        check(3, v, 32'h1);

        // R2: reset mid-operation restores every register
        bus_wr(A, 32'h7);
        bus_wr(G, 32'h9);
        bus_wr(M, 32'h0003_0001);
        ticks(2);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(2, {31'd0, irq}, 32'h0);
        bus_rd(M, v); check(2, v, 32'h0000_8000);
        bus_rd(A, v); check(2, v, 32'hFFFF_FFFF);
        bus_rd(G, v); check(2, v, 32'h0);
        bus_rd(C, v); check(2, v, 32'h0);
        bus_rd(S, v); check(2, v, 32'h0);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule